// File: doc/BRIEF.md
# Trusted Boot Configuration Register

This block is a single 32-bit configuration register for a low-power chip. While the part is still before boot, the flash controller presents a configuration word with a load strobe. The register takes that word only when the read is clean. A read that reports an error, or a word that is blank, leaves the register at its reset value. The block acts on the first load strobe after reset and then closes its boot window. It ignores every later strobe until the next reset.

After boot, software changes the register through a simple write port with one enable per byte. These writes only take effect while an external 2-bit lock code is open. The block drives the raw register value and a few decoded outputs:

- the effective 32 kHz clock source, which falls back to the always-available internal RC source when deep sleep is entered with a source that cannot survive it;
- the three deep-sleep watchdog settings.

Top module: `bootcfg_reg`

## Requirements
- R1: After a synchronous active-low reset, `cfg_q` reads 0x840E4000 and the boot window is open, so the next load strobe is evaluated.
- R2: A load strobe in the open window, with `ld_fail` low, `ld_blank` low and a word other than 0xFFFFFFFF, makes `cfg_q` equal that word from the next clock.
- R3: A load strobe in the open window with `ld_fail` high leaves `cfg_q` unchanged.
- R4: A load strobe in the open window with `ld_blank` high, or with the word 0xFFFFFFFF (blank), leaves `cfg_q` unchanged.
- R5: The first load strobe after reset closes the window, whether its word was taken or not. Later load strobes never change `cfg_q`.
- R6: A write (`wr_en` high) with `lock` equal to 2'b00 replaces exactly the bytes of `cfg_q` whose bit in `wr_be` is set. Bit k covers bits 8k+7:8k. Other bytes keep their value.
- R7: A write with `lock` other than 2'b00 leaves `cfg_q` unchanged.
- R8: When a load strobe arrives in the open window in the same cycle as a write, the load decides the outcome. The write is discarded even if the load word is rejected.
- R9: `eff_clksel` equals `cfg_q[13:12]` (11 LPRC, 10 SOSC, 01 POSC, 00 FRC). The exception is `ds_entry` high while bit 13 is 0 (FRC or POSC): then it reads 2'b11.
- R10: `wdt_ps` reflects `cfg_q[25:21]`, `wdt_en` reflects `cfg_q[27]`, and `wdt_lprc` reflects `cfg_q[26]` (1 selects LPRC, 0 selects SOSC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_stb | input | 1 | Flash configuration word valid |
| ld_word | input | 32 | Flash configuration word |
| ld_fail | input | 1 | Flash read reported a failure |
| ld_blank | input | 1 | Flash location reported blank or erased |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| wr_be | input | 4 | Byte enables for the write |
| lock | input | 2 | Lock code; 2'b00 opens writes |
| ds_entry | input | 1 | Deep sleep is being entered |
| cfg_q | output | 32 | Raw register value |
| eff_clksel | output | 2 | Effective 32 kHz clock source |
| wdt_en | output | 1 | Deep-sleep watchdog enable |
| wdt_lprc | output | 1 | Deep-sleep watchdog reference select |
| wdt_ps | output | 5 | Deep-sleep watchdog postscale |

## Verification
A trusted load and a software write can fall in the same cycle, because the write port is not held off during boot.

The bench provokes this in three ways, each with the lock open and all bytes enabled:
- together with an accepted load;
- together with a failed load;
- after the window has closed.

The scoreboard expects the following outcomes:
- In the accepted case, the flash word.
- In the failed case, the untouched reset value.
- In the late case, the written data.

A dropped or wrongly preferred write therefore shows up at `cfg_q` on the next cycle.

// File: rtl/bootcfg_pkg.sv
// Package: shared constants for the boot configuration register.
// Assumes a 32-bit register whose field positions are fixed by the consumers.
package bootcfg_pkg;
    localparam int unsigned CFG_W       = 32;
    localparam int unsigned BYTE_W      = 8;
    localparam logic [31:0] CFG_RST     = 32'h840E_4000;
    localparam int unsigned CLKSEL_LSB  = 12;
    localparam int unsigned WDT_EN_BIT  = 27;
    localparam int unsigned WDT_REF_BIT = 26;
    localparam int unsigned WDT_PS_LSB  = 21;
    localparam int unsigned WDT_PS_W    = 5;
    localparam logic [1:0]  LOCK_OPEN   = 2'b00;
    localparam logic [1:0]  CLK_LPRC    = 2'b11;

    // Outcome of a load strobe as seen by the register update.
    typedef struct packed {
        logic take;    // strobe consumed the cycle (window was open)
        logic commit;  // word is trusted and must be stored
    } load_dec_t;
endpackage

// File: rtl/bootcfg_trust.sv
// Module: bootcfg_trust
// Tracks the one-shot boot window and qualifies the flash word.
// Assumes ld_fail/ld_blank are valid in the same cycle as ld_stb.
module bootcfg_trust
    import bootcfg_pkg::*;
#(
    parameter int unsigned DATA_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic [DATA_W-1:0] ld_word,
    input  logic              ld_fail,
    input  logic              ld_blank,
    output logic              win_o,
    output load_dec_t         dec_o
);
    localparam logic [DATA_W-1:0] BLANK_WORD = '1;

    logic win_q;
    logic word_ok;

    // Word is trusted only with no error and no blank indication.
    always_comb begin
        word_ok = !ld_fail && !ld_blank && (ld_word != BLANK_WORD);
    end

    // Decode the load strobe against the window.
    always_comb begin
        dec_o.take   = ld_stb && win_q;
        dec_o.commit = ld_stb && win_q && word_ok;
    end

    // Window opens at reset and closes on the first strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b1;
        end else if (ld_stb) begin
            win_q <= 1'b0;
        end
    end

    assign win_o = win_q;

    // R5
    window_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_q |=> !win_q);

    // R5
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_q) |-> $past(ld_stb));
endmodule

// File: rtl/bootcfg_wrmerge.sv
// Module: bootcfg_wrmerge
// Merges a byte-enabled software write into the current value under the lock.
// Assumes DATA_W is a whole number of bytes.
module bootcfg_wrmerge
    import bootcfg_pkg::*;
#(
    parameter int unsigned DATA_W = CFG_W
) (
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/BYTE_W-1:0] wr_be,
    input  logic [1:0]               lock,
    input  logic                     blocked,
    input  logic [DATA_W-1:0]        cur,
    output logic                     hit_o,
    output logic [DATA_W-1:0]        merged_o
);
    localparam int unsigned NBYTES = DATA_W / BYTE_W;

    // Write lands only with the lock open and no load owning the cycle.
    always_comb begin
        hit_o = wr_en && (lock == LOCK_OPEN) && !blocked && (|wr_be);
    end

    // Per-byte select between new data and current value.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign merged_o[b*BYTE_W +: BYTE_W] =
            wr_be[b] ? wr_data[b*BYTE_W +: BYTE_W] : cur[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/bootcfg_decode.sv
// Module: bootcfg_decode
// Produces the effective clock source and the watchdog fields.
// Assumes ds_entry is held for as long as the fallback must apply.
module bootcfg_decode
    import bootcfg_pkg::*;
#(
    parameter int unsigned DATA_W = CFG_W
) (
    input  logic                cfg,
    input  logic [DATA_W-1:0]   cfg_v,
    input  logic                ds_entry,
    output logic [1:0]          eff_clksel,
    output logic                wdt_en,
    output logic                wdt_lprc,
    output logic [WDT_PS_W-1:0] wdt_ps
);
    logic [1:0] raw_sel;
    logic       no_ds_src;

    // Sources with bit 1 clear (FRC, POSC) cannot survive deep sleep.
    always_comb begin
        raw_sel    = cfg_v[CLKSEL_LSB +: 2];
        no_ds_src  = !raw_sel[1];
        eff_clksel = (cfg && ds_entry && no_ds_src) ? CLK_LPRC : raw_sel;
    end

    // Watchdog field extraction.
    always_comb begin
        wdt_en   = cfg_v[WDT_EN_BIT];
        wdt_lprc = cfg_v[WDT_REF_BIT];
        wdt_ps   = cfg_v[WDT_PS_LSB +: WDT_PS_W];
    end
endmodule

// File: rtl/bootcfg_reg.sv
// Module: bootcfg_reg (top)
// Boot configuration register: trusted one-shot flash load, lock-gated
// byte writes, and decoded clock/watchdog outputs.
// Assumes all inputs are synchronous to clk.
module bootcfg_reg
    import bootcfg_pkg::*;
#(
    parameter int unsigned DATA_W    = CFG_W,
    parameter logic [31:0] RESET_VAL = CFG_RST
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_stb,
    input  logic [DATA_W-1:0]        ld_word,
    input  logic                     ld_fail,
    input  logic                     ld_blank,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/BYTE_W-1:0] wr_be,
    input  logic [1:0]               lock,
    input  logic                     ds_entry,
    output logic [DATA_W-1:0]        cfg_q,
    output logic [1:0]               eff_clksel,
    output logic                     wdt_en,
    output logic                     wdt_lprc,
    output logic [WDT_PS_W-1:0]      wdt_ps
);
    load_dec_t         ld_dec;
    logic              win;
    logic              wr_hit;
    logic [DATA_W-1:0] wr_merged;

    bootcfg_trust #(.DATA_W(DATA_W)) i_trust (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_stb   (ld_stb),
        .ld_word  (ld_word),
        .ld_fail  (ld_fail),
        .ld_blank (ld_blank),
        .win_o    (win),
        .dec_o    (ld_dec)
    );

    bootcfg_wrmerge #(.DATA_W(DATA_W)) i_wrmerge (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .lock     (lock),
        .blocked  (ld_dec.take),
        .cur      (cfg_q),
        .hit_o    (wr_hit),
        .merged_o (wr_merged)
    );

    bootcfg_decode #(.DATA_W(DATA_W)) i_decode (
        .cfg        (1'b1),
        .cfg_v      (cfg_q),
        .ds_entry   (ds_entry),
        .eff_clksel (eff_clksel),
        .wdt_en     (wdt_en),
        .wdt_lprc   (wdt_lprc),
        .wdt_ps     (wdt_ps)
    );

    // Register update: trusted load first, then gated software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RESET_VAL[DATA_W-1:0];
        end else if (ld_dec.commit) begin
            cfg_q <= ld_word;
        end else if (wr_hit) begin
            cfg_q <= wr_merged;
        end
    end

    // R2
    load_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_dec.commit |=> cfg_q == $past(ld_word));

    // R3
    fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && win && ld_fail) |=> $stable(cfg_q));

    // R7
    lock_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock != LOCK_OPEN && !(ld_stb && win)) |=> $stable(cfg_q));

    // R9
    ds_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_entry && !cfg_q[CLKSEL_LSB+1]) |-> eff_clksel == CLK_LPRC);
endmodule

// File: tb/test_bootcfg_reg.sv
module test_bootcfg_reg;
    localparam time PER = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_stb = 1'b0, ld_fail = 1'b0, ld_blank = 1'b0;
    logic [31:0] ld_word = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [1:0]  lock = 2'b11;
    logic        ds_entry = 1'b0;
    logic [31:0] cfg_q;
    logic [1:0]  eff_clksel;
    logic        wdt_en, wdt_lprc;
    logic [4:0]  wdt_ps;

    typedef struct {
        logic [31:0] cfg;
        logic [1:0]  clk;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_cfg;
    logic        m_win;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #(PER/2) clk = ~clk;

    bootcfg_reg i_bootcfg_reg (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_word(ld_word),
        .ld_fail(ld_fail), .ld_blank(ld_blank), .wr_en(wr_en),
        .wr_data(wr_data), .wr_be(wr_be), .lock(lock), .ds_entry(ds_entry),
        .cfg_q(cfg_q), .eff_clksel(eff_clksel), .wdt_en(wdt_en),
        .wdt_lprc(wdt_lprc), .wdt_ps(wdt_ps)
    );

    function automatic logic [1:0] exp_clk();
        return (ds_entry && !m_cfg[13]) ? 2'b11 : m_cfg[13:12];
    endfunction

    task automatic push(string req);
        exp_t e;
        e.cfg = m_cfg;
        e.clk = exp_clk();
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle();
        ld_stb = 0; ld_fail = 0; ld_blank = 0; wr_en = 0; wr_be = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_cfg = 32'h840E_4000;
        m_win = 1;
        push("R1");
    endtask

    // One cycle of load and/or write, then the model update and the expectation.
    task automatic cycle(input bit ld, input logic [31:0] w, input bit f, input bit b,
                         input bit wr, input logic [31:0] d, input logic [3:0] be,
                         input logic [1:0] lk, input string req);
        @(negedge clk);
        ld_stb = ld; ld_word = w; ld_fail = f; ld_blank = b;
        wr_en = wr; wr_data = d; wr_be = be; lock = lk;
        @(negedge clk);
        idle();
        if (ld && m_win) begin
            if (!f && !b && w != 32'hFFFF_FFFF) m_cfg = w;
            m_win = 0;
        end else if (wr && lk == 2'b00) begin
            for (int k = 0; k < 4; k++)
                if (be[k]) m_cfg[k*8 +: 8] = d[k*8 +: 8];
        end
        push(req);
    endtask

    task automatic set_ds(input bit v, input string req);
        @(negedge clk);
        ds_entry = v;
        push(req);
    endtask

    // Monitor: pops expectations a quarter period after each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(PER/4);
            while (sb.size() > 0) begin
                e = sb.pop_front();
                n_chk++;
                if (cfg_q !== e.cfg || eff_clksel !== e.clk ||
                    wdt_ps !== e.cfg[25:21] || wdt_en !== e.cfg[27] ||
                    wdt_lprc !== e.cfg[26]) begin
                    n_fail++;
                    $display("FAIL %s: cfg=%h clk=%b ps=%h en=%b ref=%b expected cfg=%h clk=%b (R10 fields from cfg)",
                             e.req, cfg_q, eff_clksel, wdt_ps, wdt_en, wdt_lprc, e.cfg, e.clk);
                end
            end
        end
    end

    initial begin
        #(PER * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        set_ds(1, "R9 reset FRC falls back");
        set_ds(0, "R9 no deep sleep");
        cycle(0, 0, 0, 0, 1, 32'h1234_5678, 4'hF, 2'b01, "R7 lock 01");
        cycle(0, 0, 0, 0, 1, 32'h1234_5678, 4'hF, 2'b11, "R7 lock 11");
        cycle(0, 0, 0, 0, 1, 32'h1234_5678, 4'b0011, 2'b00, "R6 low bytes");
        cycle(1, 32'h0C6A_1000, 1, 0, 0, 0, 0, 2'b11, "R3 fail keeps");
        cycle(1, 32'h0C6A_1000, 0, 0, 0, 0, 0, 2'b11, "R5 late load ignored");
        do_reset();
        cycle(1, 32'h0C6A_1000, 0, 1, 0, 0, 0, 2'b11, "R4 blank flag");
        do_reset();
        cycle(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 2'b11, "R4 all-ones word");
        do_reset();
        cycle(1, 32'h0C6A_1000, 0, 0, 0, 0, 0, 2'b11, "R2 R10 trusted load");
        set_ds(1, "R9 POSC falls back");
        cycle(1, 32'h0000_0000, 0, 0, 0, 0, 0, 2'b11, "R5 second load ignored");
        cycle(0, 0, 0, 0, 1, 32'h0000_2000, 4'b0010, 2'b00, "R6 R9 SOSC kept in deep sleep");
        set_ds(0, "R9 SOSC");
        do_reset();
        cycle(1, 32'hA5A5_A5A5, 0, 0, 1, 32'h1111_1111, 4'hF, 2'b00, "R8 load beats write");
        do_reset();
        cycle(1, 32'hA5A5_A5A5, 1, 0, 1, 32'h1111_1111, 4'hF, 2'b00, "R8 failed load drops write");
        cycle(1, 32'hA5A5_A5A5, 0, 0, 1, 32'h3C00_3000, 4'hF, 2'b00, "R8 R5 write after window");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule